// File: doc/BRIEF.md
# Brute-Force Stream-Cipher Key Search Engine

This block is one search engine for a 24-bit stream-cipher key. A system places many copies side by side. Each copy gets its own start key and all copies share one stride equal to the copy count, so each copy sweeps its own interleaved slice of the key space. For every candidate key the engine runs the key schedule over an internal 256-by-8 single-ported state memory. It then generates keystream and XORs it with a length-prefixed ciphertext that it reads from an external memory port. Each recovered byte goes to an external plaintext write port.

A candidate is accepted only if every recovered byte lies in the printable range. The first byte outside that range abandons the candidate, and the engine moves on to the next key in its slice. The engine stops with a found flag and the key, or with an exhausted flag when its slice is used up. A stop input abandons the search at any time.

Top module: `rc4_key_search`

## Requirements
- R1: After reset, busy_o, found_o, exhausted_o and pt_we_o are all low.
- R2: A start_i pulse while busy_o is low loads key_start_i as the first candidate, and busy_o is high from the next cycle.
- R3: The key schedule fills S[x]=x for all 256 entries. Then, for x from 0 to 255, it sets j = j + S[x] + k[x mod 3] and swaps S[x] and S[j]. Key byte k[0] is bits 23:16 of the candidate, k[1] is bits 15:8 and k[2] is bits 7:0.
- R4: ct_data_i is valid one cycle after ct_addr_o. Ciphertext address 0 holds the message length L, and addresses 1..L hold the data. The length is written to plaintext address 0. Plaintext byte n is written to address n as ct[n] XOR z_n, where z_n comes from keystream generation: i=j=0; then i=i+1, j=j+S[i], swap S[i] and S[j], z=S[S[i]+S[j]].
- R5: A candidate is accepted only when all L recovered bytes lie in 0x20..0x7E. The first byte outside that range rejects the candidate at once.
- R6: Each rejected candidate is followed by the candidate plus NUM_CORES. key_o shows the current candidate and changes only on a start or on such a step.
- R7: When a candidate is rejected and adding NUM_CORES would pass 0xFFFFFF, exhausted_o rises and busy_o falls.
- R8: On acceptance, found_o rises and busy_o falls. found_o and key_o then hold until the next start_i or stop_i.
- R9: stop_i takes priority. One cycle later busy_o, found_o and exhausted_o are all low.
- R10: With L = 0, the first candidate is accepted.
- R11: start_i while busy_o is high is ignored and the search continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search from key_start_i |
| stop_i | input | 1 | Abandon the search and go idle |
| key_start_i | input | 24 | First candidate key of this engine |
| ct_addr_o | output | 8 | Ciphertext read address |
| ct_data_i | input | 8 | Ciphertext byte, one cycle after the address |
| pt_addr_o | output | 8 | Plaintext write address |
| pt_data_o | output | 8 | Plaintext write data |
| pt_we_o | output | 1 | Plaintext write strobe |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | A candidate was accepted |
| exhausted_o | output | 1 | Slice used up without a match |
| key_o | output | 24 | Current candidate; the accepted key while found_o is high |

## Verification
The assertions take three things for granted. The ciphertext memory answers with a registered read of exactly one cycle. Its contents do not change while busy_o is high. start_i and stop_i are single-cycle pulses driven away from the clock edge. The bench models the ciphertext store as a registered memory and rewrites it only while the engine is idle. It drives each control as a one-cycle pulse on the falling edge. It picks start keys so that each search covers only a handful of candidates before it hits the planted key or the top of the key space.

// File: rtl/rc4_search_pkg.sv
package rc4_search_pkg;
  localparam logic [7:0] PRINT_LO = 8'h20;
  localparam logic [7:0] PRINT_HI = 8'h7E;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEN_REQ, ST_LEN_CAP, ST_FILL,
    ST_KS_RDI, ST_KS_RDJ, ST_KS_WRI, ST_KS_WRJ,
    ST_GN_RDI, ST_GN_RDJ, ST_GN_WRI, ST_GN_WRJ,
    ST_GN_RDK, ST_GN_CHK, ST_FOUND, ST_EXHAUST
  } seq_state_e;

  function automatic logic is_printable(input logic [7:0] b);
    return (b >= PRINT_LO) && (b <= PRINT_HI);
  endfunction
endpackage

// File: rtl/rc4_sbox_ram.sv
module rc4_sbox_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/rc4_key_stepper.sv
module rc4_key_stepper #(
  parameter int unsigned KEY_W  = 24,
  parameter int unsigned STRIDE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] load_key_i,
  input  logic             adv_i,
  output logic [KEY_W-1:0] key_o,
  output logic             last_o
);
  localparam int unsigned SUM_W = KEY_W + 1;

  logic [KEY_W-1:0] key_q;
  logic [SUM_W-1:0] sum;

  assign sum    = {1'b0, key_q} + SUM_W'(STRIDE);
  assign last_o = sum[KEY_W];
  assign key_o  = key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                key_q <= '0;
    else if (load_i)            key_q <= load_key_i;
    else if (adv_i && !last_o)  key_q <= sum[KEY_W-1:0];
  end

  // R6: a step moves exactly one stride
  a_r6_stride_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_o && !load_i) |=> (key_o == $past(key_o) + KEY_W'(STRIDE)));

  // R6: no other change without a load
  a_r6_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(key_o));
endmodule

// File: rtl/rc4_search_seq.sv
module rc4_search_seq import rc4_search_pkg::*; #(
  parameter int unsigned KEY_BYTES = 3,
  localparam int unsigned KEY_W = 8 * KEY_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [KEY_W-1:0] cur_key_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             adv_o,
  output logic [7:0]       ram_addr_o,
  output logic             ram_we_o,
  output logic [7:0]       ram_wdata_o,
  input  logic [7:0]       ram_rdata_i,
  output logic [7:0]       ct_addr_o,
  input  logic [7:0]       ct_data_i,
  output logic [7:0]       pt_addr_o,
  output logic [7:0]       pt_data_o,
  output logic             pt_we_o,
  output logic             busy_o,
  output logic             found_o,
  output logic             exhausted_o
);
  localparam int unsigned KIDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

  seq_state_e        state_q;
  logic [7:0]        i_q, j_q, si_q, sj_q, ct_q, len_q, n_q;
  logic [KIDX_W-1:0] kidx_q, kidx_nx;
  logic [7:0]        key_bytes [KEY_BYTES];
  logic [7:0]        key_byte, i_nx, j_ks, j_gn, pt_byte;
  logic              byte_ok;

  // most significant byte is schedule byte 0
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_kbyte
    assign key_bytes[g] = cur_key_i[KEY_W-1-8*g -: 8];
  end

  assign key_byte = key_bytes[kidx_q];
  assign kidx_nx  = (kidx_q == KIDX_W'(KEY_BYTES-1)) ? '0 : kidx_q + 1'b1;
  assign i_nx     = i_q + 8'd1;
  assign j_ks     = j_q + ram_rdata_i + key_byte;
  assign j_gn     = j_q + ram_rdata_i;
  assign pt_byte  = ct_q ^ ram_rdata_i;
  assign byte_ok  = is_printable(pt_byte);

  assign found_o     = (state_q == ST_FOUND);
  assign exhausted_o = (state_q == ST_EXHAUST);
  assign busy_o      = !(state_q inside {ST_IDLE, ST_FOUND, ST_EXHAUST});
  assign load_o      = start_i && !busy_o && !stop_i;
  assign adv_o       = (state_q == ST_GN_CHK) && !byte_ok && !last_i && !stop_i;

  assign ct_addr_o = n_q;
  assign pt_addr_o = n_q;
  assign pt_we_o   = (state_q == ST_LEN_CAP) || (state_q == ST_GN_CHK);
  assign pt_data_o = (state_q == ST_LEN_CAP) ? ct_data_i : pt_byte;

  always_comb begin
    ram_addr_o  = i_q;
    ram_we_o    = 1'b0;
    ram_wdata_o = i_q;
    case (state_q)
      ST_FILL:              ram_we_o = 1'b1;
      ST_KS_RDJ:            ram_addr_o = j_ks;
      ST_KS_WRI, ST_GN_WRI: begin ram_we_o = 1'b1; ram_wdata_o = ram_rdata_i; end
      ST_KS_WRJ, ST_GN_WRJ: begin ram_addr_o = j_q; ram_we_o = 1'b1; ram_wdata_o = si_q; end
      ST_GN_RDI:            ram_addr_o = i_nx;
      ST_GN_RDJ:            ram_addr_o = j_gn;
      ST_GN_RDK:            ram_addr_o = si_q + sj_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      i_q <= '0; j_q <= '0; si_q <= '0; sj_q <= '0;
      ct_q <= '0; len_q <= '0; n_q <= '0; kidx_q <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_FOUND, ST_EXHAUST:
          if (start_i) begin n_q <= '0; state_q <= ST_LEN_REQ; end
        ST_LEN_REQ: state_q <= ST_LEN_CAP;
        ST_LEN_CAP: begin len_q <= ct_data_i; i_q <= '0; state_q <= ST_FILL; end
        ST_FILL: begin
          i_q <= i_nx;
          if (i_q == 8'hFF) begin j_q <= '0; kidx_q <= '0; state_q <= ST_KS_RDI; end
        end
        ST_KS_RDI: state_q <= ST_KS_RDJ;
        ST_KS_RDJ: begin si_q <= ram_rdata_i; j_q <= j_ks; state_q <= ST_KS_WRI; end
        ST_KS_WRI: state_q <= ST_KS_WRJ;
        ST_KS_WRJ: begin
          i_q    <= i_nx;
          kidx_q <= kidx_nx;
          if (i_q == 8'hFF) begin
            j_q     <= '0;
            n_q     <= 8'd1;
            state_q <= (len_q == 8'd0) ? ST_FOUND : ST_GN_RDI;
          end else begin
            state_q <= ST_KS_RDI;
          end
        end
        ST_GN_RDI: begin i_q <= i_nx; state_q <= ST_GN_RDJ; end
        ST_GN_RDJ: begin
          si_q <= ram_rdata_i; j_q <= j_gn; ct_q <= ct_data_i; state_q <= ST_GN_WRI;
        end
        ST_GN_WRI: begin sj_q <= ram_rdata_i; state_q <= ST_GN_WRJ; end
        ST_GN_WRJ: state_q <= ST_GN_RDK;
        ST_GN_RDK: state_q <= ST_GN_CHK;
        ST_GN_CHK: begin
          if (!byte_ok) begin
            i_q     <= '0;
            state_q <= last_i ? ST_EXHAUST : ST_FILL;
          end else if (n_q == len_q) begin
            state_q <= ST_FOUND;
          end else begin
            n_q     <= n_q + 8'd1;
            state_q <= ST_GN_RDI;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !stop_i) |=> busy_o);

  a_r4_pt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_we_o && state_q == ST_GN_CHK) |-> (pt_addr_o != 8'd0 && pt_addr_o <= len_q));

  a_r5_reject_no_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_we_o && pt_addr_o != 8'd0 && !is_printable(pt_data_o)) |=> !found_o);

  a_r7_exhaust_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exhausted_o) |-> $past(last_i));

  a_r8_found_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i && !stop_i) |=> found_o);

  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && !found_o && !exhausted_o));

  a_r11_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |-> !load_o);
endmodule

// File: rtl/rc4_key_search.sv
module rc4_key_search #(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned KEY_BYTES = 3,
  localparam int unsigned KEY_W = 8 * KEY_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [KEY_W-1:0] key_start_i,
  output logic [7:0]       ct_addr_o,
  input  logic [7:0]       ct_data_i,
  output logic [7:0]       pt_addr_o,
  output logic [7:0]       pt_data_o,
  output logic             pt_we_o,
  output logic             busy_o,
  output logic             found_o,
  output logic             exhausted_o,
  output logic [KEY_W-1:0] key_o
);
  logic       load, adv, last;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic       ram_we;

  rc4_key_stepper #(.KEY_W(KEY_W), .STRIDE(NUM_CORES)) u_stepper (
    .clk_i, .rst_ni,
    .load_i(load), .load_key_i(key_start_i), .adv_i(adv),
    .key_o, .last_o(last)
  );

  rc4_sbox_ram #(.AW(8), .DW(8)) u_sbox (
    .clk_i, .we_i(ram_we), .addr_i(ram_addr), .wdata_i(ram_wdata), .rdata_o(ram_rdata)
  );

  rc4_search_seq #(.KEY_BYTES(KEY_BYTES)) u_seq (
    .clk_i, .rst_ni, .start_i, .stop_i,
    .cur_key_i(key_o), .last_i(last), .load_o(load), .adv_o(adv),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .ct_addr_o, .ct_data_i, .pt_addr_o, .pt_data_o, .pt_we_o,
    .busy_o, .found_o, .exhausted_o
  );

  // R8: accepted key held
  a_r8_key_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i && !stop_i) |=> $stable(key_o));

  // R1: no plaintext writes while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !pt_we_o);
endmodule

// File: tb/rc4_key_search_bench.sv
module rc4_key_search_bench;
  localparam int unsigned CORES = 4;
  localparam int unsigned LIMIT = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [23:0] key_start = '0;
  logic [7:0]  ct_addr, ct_rdata, pt_addr, pt_data;
  logic        pt_we, busy, found, exhausted;
  logic [23:0] key;

  logic [7:0] ct_mem [256];
  logic [7:0] pt_mem [256];
  logic [7:0] exp_pt [256];

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rc4_key_search #(.NUM_CORES(CORES)) u_rc4_key_search (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .key_start_i(key_start),
    .ct_addr_o(ct_addr), .ct_data_i(ct_rdata), .pt_addr_o(pt_addr), .pt_data_o(pt_data),
    .pt_we_o(pt_we), .busy_o(busy), .found_o(found), .exhausted_o(exhausted), .key_o(key)
  );

  always_ff @(posedge clk) ct_rdata <= ct_mem[ct_addr];
  always @(posedge clk) if (pt_we) pt_mem[pt_addr] <= pt_data;

  // vectors: start key, planted key, length, expect found
  localparam int NV = 5;
  localparam logic [23:0] V_START [NV] = '{24'h000001, 24'h123400, 24'hA5C3F0, 24'hFFFFF8, 24'hFFFFFF};
  localparam logic [23:0] V_TGT   [NV] = '{24'h000009, 24'h123404, 24'hA5C3F0, 24'h000005, 24'hFFFFFF};
  localparam int          V_LEN   [NV] = '{10, 12, 5, 10, 8};
  localparam bit          V_FOUND [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference cipher, key bytes most significant first
  task automatic build_msg(input logic [23:0] k, input int len, input int seed);
    int s [256];
    int j, t, ii, jj;
    for (int x = 0; x < 256; x++) s[x] = x;
    j = 0;
    for (int x = 0; x < 256; x++) begin
      j = (j + s[x] + int'((k >> (8 * (2 - (x % 3)))) & 24'hFF)) % 256;
      t = s[x]; s[x] = s[j]; s[j] = t;
    end
    ii = 0; jj = 0;
    ct_mem[0] = 8'(len);
    for (int n = 1; n <= len; n++) begin
      ii = (ii + 1) % 256;
      jj = (jj + s[ii]) % 256;
      t = s[ii]; s[ii] = s[jj]; s[jj] = t;
      exp_pt[n] = 8'(8'h41 + ((seed * 7 + n * 3) % 58));
      ct_mem[n] = exp_pt[n] ^ 8'(s[(s[ii] + s[jj]) % 256]);
    end
  endtask

  task automatic clear_pt();
    for (int a = 0; a < 256; a++) pt_mem[a] <= 8'hEE;
  endtask

  task automatic pulse_start(input logic [23:0] k);
    @(negedge clk); key_start = k; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int c = 0;
    while (busy && c < LIMIT) begin @(negedge clk); c++; end
    check(c < LIMIT, tag, c, LIMIT);
  endtask

  task automatic check_pt(input int len, input string tag);
    int bad = 0;
    for (int n = 1; n <= len; n++) if (pt_mem[n] !== exp_pt[n]) bad++;
    check(bad == 0, tag, bad, 0);
    check(pt_mem[0] == 8'(len), "R4 length byte", int'(pt_mem[0]), len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) ct_mem[a] = 8'h00;
    clear_pt();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !found && !exhausted && !pt_we, "R1 reset outputs",
          {busy, found, exhausted, pt_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !found && !exhausted, "R1 after release", {busy, found, exhausted}, 0);

    for (int v = 0; v < NV; v++) begin
      build_msg(V_TGT[v], V_LEN[v], v);
      clear_pt();
      pulse_start(V_START[v]);
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      wait_idle("R6 search finishes");
      check(found == V_FOUND[v], "R5 found flag", found, V_FOUND[v]);
      check(exhausted == !V_FOUND[v], "R7 exhausted flag", exhausted, !V_FOUND[v]);
      if (V_FOUND[v]) begin
        check(key == V_TGT[v], "R6 stride key", key, V_TGT[v]);
        check_pt(V_LEN[v], "R3 R4 plaintext");
      end
    end

    // R8 result holds
    build_msg(24'h000203, 6, 9);
    pulse_start(24'h0001FF);
    wait_idle("R8 search");
    repeat (25) @(negedge clk);
    check(found && !busy && key == 24'h000203, "R8 found held", key, 24'h000203);

    // R10 zero length
    ct_mem[0] = 8'h00;
    clear_pt();
    pulse_start(24'h00ABCD);
    wait_idle("R10 search");
    check(found && key == 24'h00ABCD, "R10 empty accepted", key, 24'h00ABCD);
    check(pt_mem[0] == 8'h00, "R10 length byte", int'(pt_mem[0]), 0);

    // R11 start while busy ignored
    build_msg(24'h000010, 10, 3);
    clear_pt();
    pulse_start(24'h000008);
    repeat (40) @(negedge clk);
    pulse_start(24'h000100);
    wait_idle("R11 search");
    check(found && key == 24'h000010, "R11 restart ignored", key, 24'h000010);
    check_pt(10, "R11 plaintext");

    // R9 stop
    build_msg(24'h000040, 10, 4);
    pulse_start(24'h000000);
    repeat (100) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(!busy && !found && !exhausted, "R9 stop clears", {busy, found, exhausted}, 0);
    repeat (20) @(negedge clk);
    check(!busy && !pt_we, "R9 stays idle", {busy, pt_we}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule